// File: doc/BRIEF.md
# Distributed Bank-Set Search Controller

This controller finds a cache line whose set is spread across a row of banks numbered by distance: bank 0 is nearest the controller and the last bank is farthest. A lookup carries a tag and a search policy. The controller sends probe strobes to chosen banks and broadcasts the tag to them. It then gathers the per-bank hit/miss replies and returns either the index of the bank that holds the line or a miss. A far bank takes longer to reply than a near one.

The controller groups probes into waves, and the policy decides the waves. The serial policy probes one bank at a time. The broadcast policy probes every bank at once. The near-first policy probes a few nearest banks and then all the rest. The subset policy walks outward through fixed-size groups of neighbouring banks. The search stops at the first hit, and any replies still owed are absorbed without effect. Each result also reports how many probes the lookup sent, so probe traffic can be compared across policies. Only one lookup is handled at a time.

Top module: `bank_search_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, req_ready is 1 and res_valid and every probe_valid bit are 0.
- R2: With req_mode = 0 (serial), bank 0 is probed in the cycle after acceptance. Bank k+1 is probed in the cycle after the miss reply of bank k arrives. At most one probe_valid bit is high in any cycle.
- R3: With req_mode = 1 (broadcast), all NUM_BANKS banks are probed together in the cycle after acceptance, and nothing is probed after that.
- R4: With req_mode = 2 (near-first), banks 0 to NEAR_CNT-1 are probed in the cycle after acceptance. If all of them miss, banks NEAR_CNT to NUM_BANKS-1 are probed together in the cycle after the last of those misses arrives.
- R5: With req_mode = 3 (subset), group g holds banks g*GROUP_SZ to g*GROUP_SZ+GROUP_SZ-1, and the last group may be shorter. Group 0 is probed in the cycle after acceptance. Group g+1 is probed in the cycle after the last miss of group g arrives.
- R6: The first hit reply ends the lookup. res_valid is high for exactly one cycle, the cycle after that reply, with res_hit = 1 and res_bank set to the bank that replied. When several hits arrive in the same cycle, the lowest bank index wins. No further probe follows a hit.
- R7: A miss is reported only after every bank has replied with a miss. It is reported in the cycle after the last reply, with res_hit = 0 and res_probes = NUM_BANKS.
- R8: res_probes equals the number of probe strobes the lookup sent.
- R9: req_ready is 0 from the acceptance edge until the result has been given and every probe of the lookup has replied. A req_valid presented while req_ready is 0 has no effect.
- R10: A reply on a bank that has no probe outstanding, whether hit or miss, has no effect.
- R11: While a lookup's probes are being sent, probe_tag equals the tag accepted with that lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Controller can accept a lookup |
| req_tag | input | TAG_W | Tag to search for |
| req_mode | input | 2 | Search policy: 0 serial, 1 broadcast, 2 near-first, 3 subset |
| probe_valid | output | NUM_BANKS | One-cycle probe strobe per bank |
| probe_tag | output | TAG_W | Tag sent with the probes |
| resp_valid | input | NUM_BANKS | Per-bank reply strobe |
| resp_hit | input | NUM_BANKS | Per-bank hit flag, read with resp_valid |
| res_valid | output | 1 | One-cycle result strobe |
| res_hit | output | 1 | 1 when the line was found |
| res_bank | output | $clog2(NUM_BANKS) | Bank that holds the line |
| res_probes | output | $clog2(NUM_BANKS+1) | Probes sent by the lookup |

## Verification
Take the acceptance edge as cycle 0. A wave sent at edge T has its strobes visible in cycle T. A bank with reply latency L answers at edge T+1+L, and the next wave, or a result, is registered on that same edge. So a hit in bank b of a wave sent at T gives res_valid after edge T+1+L_b. A full miss is reported after the edge of the last wave's slowest reply. req_ready rises after the latest reply of any probe the lookup sent, or after the result edge if that is later. The bench computes these edges from the policy and each bank's latency before the lookup starts. It then samples 1 ns after every edge, so it can compare the exact cycle of each probe, the result and the rise of req_ready.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic [1:0] {
    SRCH_SERIAL     = 2'd0,
    SRCH_BROAD      = 2'd1,
    SRCH_NEAR_FIRST = 2'd2,
    SRCH_SUBSET     = 2'd3
  } srch_mode_e;
endpackage

// File: rtl/bsc_wave_plan.sv
// Decides which banks belong to a given wave of a given policy, and
// whether that wave is the final one.
module bsc_wave_plan
  import bsc_pkg::*;
#(
  parameter int NB   = 8,
  parameter int NEAR = 2,
  parameter int GRP  = 3,
  parameter int WV_W = 3
) (
  input  srch_mode_e      mode,
  input  logic [WV_W-1:0] wave,
  output logic [NB-1:0]   mask,
  output logic            last
);
  localparam int NSUB = (NB + GRP - 1) / GRP;

  for (genvar b = 0; b < NB; b++) begin : g_member
    localparam bit IN_NEAR = (b < NEAR);
    localparam int GID     = b / GRP;
    assign mask[b] = (mode == SRCH_SERIAL) ? (int'(wave) == b) :
                     (mode == SRCH_BROAD)  ? (wave == '0) :
                     (mode == SRCH_NEAR_FIRST) ?
                       (IN_NEAR ? (wave == '0) : (int'(wave) == 1)) :
                     (int'(wave) == GID);
  end

  always_comb begin
    unique case (mode)
      SRCH_SERIAL:     last = (int'(wave) == NB - 1);
      SRCH_BROAD:      last = 1'b1;
      SRCH_NEAR_FIRST: last = (int'(wave) == 1);
      default:         last = (int'(wave) == NSUB - 1);
    endcase
  end
endmodule

// File: rtl/bsc_track.sv
// Per-bank outstanding-probe flags; filters replies to banks actually probed.
module bsc_track #(
  parameter int NB = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_en,
  input  logic [NB-1:0] issue_mask,
  input  logic [NB-1:0] resp_valid,
  input  logic [NB-1:0] resp_hit,
  output logic [NB-1:0] pending,
  output logic [NB-1:0] hit_vec,
  output logic          all_back
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic pend_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q <= 1'b0;
      end else begin
        pend_q <= (pend_q & ~resp_valid[b]) | (issue_en & issue_mask[b]);
      end
    end
    assign pending[b] = pend_q;
  end

  assign hit_vec  = resp_valid & resp_hit & pending;
  assign all_back = ((pending & ~resp_valid) == '0);
endmodule

// File: rtl/bsc_pick_near.sv
// Lowest-index (nearest) set bit of a request vector.
module bsc_pick_near #(
  parameter int NB = 8,
  parameter int IW = 3
) (
  input  logic [NB-1:0] req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/bank_search_ctrl.sv
module bank_search_ctrl
  import bsc_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int TAG_W     = 16,
  parameter int NEAR_CNT  = 2,
  parameter int GROUP_SZ  = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [TAG_W-1:0]               req_tag,
  input  logic [1:0]                     req_mode,
  output logic [NUM_BANKS-1:0]           probe_valid,
  output logic [TAG_W-1:0]               probe_tag,
  input  logic [NUM_BANKS-1:0]           resp_valid,
  input  logic [NUM_BANKS-1:0]           resp_hit,
  output logic                           res_valid,
  output logic                           res_hit,
  output logic [$clog2(NUM_BANKS)-1:0]   res_bank,
  output logic [$clog2(NUM_BANKS+1)-1:0] res_probes
);
  localparam int BIDX_W = $clog2(NUM_BANKS);
  localparam int CNT_W  = $clog2(NUM_BANKS + 1);
  localparam int WV_W   = BIDX_W;

  logic                 busy_q, last_q;
  srch_mode_e           mode_q, mode_sel;
  logic [WV_W-1:0]      wave_q, wave_sel;
  logic [TAG_W-1:0]     tag_q;
  logic [CNT_W-1:0]     cnt_q, pop;
  logic [NUM_BANKS-1:0] probe_q;
  logic                 rv_q, rh_q;
  logic [BIDX_W-1:0]    rb_q;
  logic [CNT_W-1:0]     rp_q;

  logic [NUM_BANKS-1:0] plan_mask, pending, hit_vec;
  logic                 plan_last, all_back, hit_any;
  logic [BIDX_W-1:0]    hit_idx;
  logic                 accept, advance, issue_en;

  assign req_ready = !busy_q && (pending == '0);
  assign accept    = req_valid && req_ready;
  assign mode_sel  = accept ? srch_mode_e'(req_mode) : mode_q;
  assign wave_sel  = accept ? '0 : wave_q + 1'b1;
  assign advance   = busy_q && !hit_any && all_back && !last_q;
  assign issue_en  = accept || advance;

  bsc_wave_plan #(
    .NB(NUM_BANKS), .NEAR(NEAR_CNT), .GRP(GROUP_SZ), .WV_W(WV_W)
  ) u_plan (
    .mode(mode_sel), .wave(wave_sel), .mask(plan_mask), .last(plan_last)
  );

  bsc_track #(.NB(NUM_BANKS)) u_track (
    .clk(clk), .rst(rst), .issue_en(issue_en), .issue_mask(plan_mask),
    .resp_valid(resp_valid), .resp_hit(resp_hit),
    .pending(pending), .hit_vec(hit_vec), .all_back(all_back)
  );

  bsc_pick_near #(.NB(NUM_BANKS), .IW(BIDX_W)) u_pick (
    .req(hit_vec), .any(hit_any), .idx(hit_idx)
  );

  always_comb begin
    pop = '0;
    for (int i = 0; i < NUM_BANKS; i++) pop = pop + CNT_W'(plan_mask[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      last_q  <= 1'b0;
      mode_q  <= SRCH_SERIAL;
      wave_q  <= '0;
      tag_q   <= '0;
      cnt_q   <= '0;
      probe_q <= '0;
      rv_q    <= 1'b0;
      rh_q    <= 1'b0;
      rb_q    <= '0;
      rp_q    <= '0;
    end else begin
      probe_q <= issue_en ? plan_mask : '0;
      rv_q    <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        mode_q <= mode_sel;
        tag_q  <= req_tag;
        wave_q <= '0;
        last_q <= plan_last;
        cnt_q  <= pop;
      end else if (busy_q) begin
        if (hit_any) begin
          busy_q <= 1'b0;
          rv_q   <= 1'b1;
          rh_q   <= 1'b1;
          rb_q   <= hit_idx;
          rp_q   <= cnt_q;
        end else if (all_back && last_q) begin
          busy_q <= 1'b0;
          rv_q   <= 1'b1;
          rh_q   <= 1'b0;
          rb_q   <= '0;
          rp_q   <= cnt_q;
        end else if (advance) begin
          wave_q <= wave_sel;
          last_q <= plan_last;
          cnt_q  <= cnt_q + pop;
        end
      end
    end
  end

  assign probe_valid = probe_q;
  assign probe_tag   = tag_q;
  assign res_valid   = rv_q;
  assign res_hit     = rh_q;
  assign res_bank    = rb_q;
  assign res_probes  = rp_q;
endmodule

// File: rtl/bsc_checker.sv
module bsc_checker #(
  parameter int NUM_BANKS = 8,
  parameter int TAG_W     = 16,
  parameter int CNT_W     = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [NUM_BANKS-1:0] probe_valid,
  input logic [TAG_W-1:0]     probe_tag,
  input logic                 res_valid,
  input logic                 res_hit,
  input logic [CNT_W-1:0]     res_probes,
  input logic [1:0]           mode_q
);
  AST_SERIAL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd0) |-> $onehot0(probe_valid)); // R2
  AST_BROAD_FULL: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd1 && (|probe_valid)) |-> (&probe_valid)); // R3
  AST_ACCEPT_ISSUES: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (|probe_valid)); // R5
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R6
  AST_MISS_ALL_PROBED: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_probes == CNT_W'(NUM_BANKS))); // R7
  AST_PROBE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (|probe_valid) |-> !req_ready); // R9
  AST_TAG_HELD: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |-> $stable(probe_tag)); // R11
endmodule

bind bank_search_ctrl bsc_checker #(
  .NUM_BANKS(NUM_BANKS), .TAG_W(TAG_W), .CNT_W($clog2(NUM_BANKS + 1))
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .probe_valid(probe_valid), .probe_tag(probe_tag), .res_valid(res_valid),
  .res_hit(res_hit), .res_probes(res_probes), .mode_q(mode_q)
);

// File: tb/bank_search_ctrl_tb.sv
`timescale 1ns/1ps
module bank_search_ctrl_tb;
  localparam int NB = 8;
  localparam int TW = 16;
  localparam int NC = 2;
  localparam int GS = 3;
  localparam int BW = $clog2(NB);
  localparam int CW = $clog2(NB + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [TW-1:0] req_tag = '0;
  logic [1:0]    req_mode = 2'd0;
  logic [NB-1:0] probe_valid;
  logic [TW-1:0] probe_tag;
  logic [NB-1:0] resp_valid, resp_hit;
  logic          res_valid, res_hit;
  logic [BW-1:0] res_bank;
  logic [CW-1:0] res_probes;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  bank_search_ctrl #(.NUM_BANKS(NB), .TAG_W(TW), .NEAR_CNT(NC), .GROUP_SZ(GS)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_tag(req_tag), .req_mode(req_mode), .probe_valid(probe_valid),
    .probe_tag(probe_tag), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .res_valid(res_valid), .res_hit(res_hit), .res_bank(res_bank),
    .res_probes(res_probes)
  );

  // Behavioural banks: reply lat[b] edges after seeing a probe.
  int            lat [NB];
  int            cnt_r [NB];
  logic [NB-1:0] hit_set = '0;
  logic [NB-1:0] inj_v = '0;

  always @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (rst) cnt_r[b] <= 0;
      else if (probe_valid[b]) cnt_r[b] <= lat[b];
      else if (cnt_r[b] > 0) cnt_r[b] <= cnt_r[b] - 1;
    end
  end

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      resp_valid[b] = (cnt_r[b] == 1) | inj_v[b];
      resp_hit[b]   = ((cnt_r[b] == 1) & hit_set[b]) | inj_v[b];
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // Expected-value model built from the requirements.
  int exp_issue [NB];
  int exp_d, exp_probes, exp_bank, exp_ready;
  bit exp_hit;

  function automatic int wave_of(input int m, input int b);
    case (m)
      0: return b;
      1: return 0;
      2: return (b < NC) ? 0 : 1;
      default: return b / GS;
    endcase
  endfunction

  function automatic int n_waves(input int m);
    case (m)
      0: return NB;
      1: return 1;
      2: return 2;
      default: return (NB + GS - 1) / GS;
    endcase
  endfunction

  task automatic model(input int m);
    int t, wend, bt, best;
    bit done;
    t = 0; done = 0; exp_probes = 0; exp_ready = 0; exp_bank = 0; exp_hit = 0;
    for (int b = 0; b < NB; b++) exp_issue[b] = -1;
    for (int w = 0; w < n_waves(m); w++) begin
      if (!done) begin
        wend = t; best = -1; bt = 1 << 30;
        for (int b = 0; b < NB; b++) begin
          if (wave_of(m, b) == w) begin
            exp_issue[b] = t;
            exp_probes++;
            if (t + 1 + lat[b] > wend) wend = t + 1 + lat[b];
            if (t + 1 + lat[b] > exp_ready) exp_ready = t + 1 + lat[b];
            if (hit_set[b] && (t + 1 + lat[b] < bt)) begin
              bt = t + 1 + lat[b];
              best = b;
            end
          end
        end
        if (best >= 0) begin
          done = 1; exp_hit = 1; exp_bank = best; exp_d = bt;
        end else begin
          t = wend;
        end
      end
    end
    if (!done) exp_d = t;
    if (exp_d > exp_ready) exp_ready = exp_d;
  endtask

  task automatic run_lookup(input int m, input logic [TW-1:0] tag, input string rq,
                            input bit poke, input int inj_bank, input int inj_n);
    int got_issue [NB];
    int pulses [NB];
    int n, got_d, res_cnt, rdy_n, bad_tag;
    logic          g_hit;
    logic [BW-1:0] g_bank;
    logic [CW-1:0] g_probes;
    model(m);
    for (int b = 0; b < NB; b++) begin got_issue[b] = -1; pulses[b] = 0; end
    got_d = -1; res_cnt = 0; rdy_n = -1; bad_tag = 0;
    g_hit = 1'b0; g_bank = '0; g_probes = '0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_mode = 2'(m); req_tag = tag;
    @(posedge clk);
    #1;
    req_valid = poke;
    if (poke) begin req_tag = ~tag; req_mode = 2'(m ^ 1); end
    n = 0;
    while (n <= exp_ready + 2 && n < 300) begin
      for (int b = 0; b < NB; b++) begin
        if (probe_valid[b]) begin
          pulses[b]++;
          if (got_issue[b] < 0) got_issue[b] = n;
          if (probe_tag !== tag) bad_tag++;
        end
      end
      if (res_valid) begin
        res_cnt++;
        if (got_d < 0) begin
          got_d = n; g_hit = res_hit; g_bank = res_bank; g_probes = res_probes;
        end
      end
      if (req_ready && rdy_n < 0) rdy_n = n;
      if (n >= exp_ready) req_valid = 1'b0;
      inj_v = '0;
      if (n == inj_n) inj_v[inj_bank] = 1'b1;
      @(posedge clk);
      #1;
      n++;
    end
    inj_v = '0;
    chk(res_cnt == 1, exp_hit ? "R6" : "R7", "result strobe count", res_cnt, 1);
    chk(got_d == exp_d, exp_hit ? "R6" : "R7", "result cycle", got_d, exp_d);
    chk(g_hit == exp_hit, exp_hit ? "R6" : "R7", "res_hit", int'(g_hit), int'(exp_hit));
    if (exp_hit) chk(int'(g_bank) == exp_bank, "R6", "res_bank", int'(g_bank), exp_bank);
    chk(int'(g_probes) == exp_probes, "R8", "res_probes", int'(g_probes), exp_probes);
    for (int b = 0; b < NB; b++) begin
      chk(got_issue[b] == exp_issue[b], rq, $sformatf("probe cycle bank %0d", b),
          got_issue[b], exp_issue[b]);
      chk(pulses[b] == (exp_issue[b] >= 0 ? 1 : 0), rq,
          $sformatf("probe count bank %0d", b), pulses[b], (exp_issue[b] >= 0 ? 1 : 0));
    end
    chk(rdy_n == exp_ready, "R9", "req_ready rise cycle", rdy_n, exp_ready);
    chk(bad_tag == 0, "R11", "probe_tag mismatches", bad_tag, 0);
  endtask

  task automatic t_reset;
    chk(req_ready === 1'b1, "R1", "req_ready in reset", int'(req_ready), 1);
    chk(res_valid === 1'b0, "R1", "res_valid in reset", int'(res_valid), 0);
    chk(probe_valid === '0, "R1", "probe_valid in reset", int'(probe_valid), 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk(req_ready === 1'b1 && res_valid === 1'b0 && probe_valid === '0, "R1",
        "outputs after reset", int'(req_ready), 1);
  endtask

  task automatic t_stray_idle;
    int seen;
    seen = 0;
    @(negedge clk); inj_v[2] = 1'b1;
    @(negedge clk); inj_v = '0;
    repeat (4) begin
      @(posedge clk); #1;
      if (res_valid || !req_ready || probe_valid != '0) seen++;
    end
    chk(seen == 0, "R10", "idle stray reply effect", seen, 0);
  endtask

  task automatic set_lat(input bit flat);
    for (int b = 0; b < NB; b++) lat[b] = flat ? 2 : b + 1;
  endtask

  task automatic t_serial;
    set_lat(0);
    hit_set = 8'b0000_1000; run_lookup(0, 16'h1234, "R2", 0, 0, -1);
    hit_set = '0;           run_lookup(0, 16'h0BAD, "R2", 0, 0, -1);
  endtask

  task automatic t_broad;
    set_lat(0);
    hit_set = 8'b0010_0000; run_lookup(1, 16'hA5A5, "R3", 0, 0, -1);
    hit_set = 8'b0000_0001; run_lookup(1, 16'h0F0F, "R3", 0, 0, -1);
    hit_set = '0;           run_lookup(1, 16'h7777, "R3", 0, 0, -1);
  endtask

  task automatic t_near;
    set_lat(0);
    hit_set = 8'b0000_0010; run_lookup(2, 16'h1111, "R4", 0, 0, -1);
    hit_set = 8'b0100_0000; run_lookup(2, 16'h2222, "R4", 0, 0, -1);
    hit_set = '0;           run_lookup(2, 16'h3333, "R4", 0, 0, -1);
  endtask

  task automatic t_subset;
    set_lat(0);
    hit_set = 8'b0001_0000; run_lookup(3, 16'h4444, "R5", 0, 0, -1);
    hit_set = 8'b1000_0000; run_lookup(3, 16'h5555, "R5", 0, 0, -1);
    hit_set = '0;           run_lookup(3, 16'h6666, "R5", 0, 0, -1);
  endtask

  task automatic t_tie;
    set_lat(1);
    hit_set = 8'b0010_1000; run_lookup(1, 16'h9999, "R6", 0, 0, -1);
    set_lat(0);
  endtask

  task automatic t_busy_poke;
    set_lat(0);
    hit_set = 8'b0100_0000; run_lookup(2, 16'hC0DE, "R9", 1, 0, -1);
  endtask

  task automatic t_stray_busy;
    set_lat(0);
    hit_set = 8'b0000_1000; run_lookup(0, 16'hBEEF, "R10", 0, 6, 1);
  endtask

  initial begin
    set_lat(0);
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_serial();
    t_broad();
    t_near();
    t_subset();
    t_tie();
    t_busy_poke();
    t_stray_busy();
    t_stray_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule